// File: doc/BRIEF.md
# Oversampled UART Serial Receiver

This block recovers bytes from an asynchronous serial line that carries one start bit, eight data bits (least significant first) and one stop bit, with no parity. The raw line first passes through a two-flop synchronizer. A third flop keeps the previous synchronized level, and the receiver uses it to spot the change from idle high to a low start bit. From the system clock frequency and the baud rate, both given as parameters, the block derives a tick sixteen times per bit period. It uses that tick to place its sample points in the middle of each bit.

A low pulse on the line is accepted as a start only if the line is still low half a bit later. Shorter dips are dropped as glitches. Each data bit and the stop bit is sampled at slot 8 of its 16 slots. A good stop bit produces the byte with a one-cycle valid strobe. A low stop bit produces a one-cycle framing-error strobe instead. The receiver is ready for the next start edge right after the stop-bit sample, so it can follow a sender whose stop bit is slightly short.

Top module: `uart_rx_os16`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rx_valid` and `rx_frame_err` are 0 and `rx_byte` is 0. With the line high at release, the receiver produces no output afterwards.
- R2: The receiver leaves idle only on a high-to-low change of the synchronized line. A line that is simply held low produces no output.
- R3: A low pulse that has ended before the middle of the start bit (slot 8 of 16) is dropped, and neither strobe fires. A proper frame that follows is received normally.
- R4: Each bit period is split into 16 slots by a fractional divider of CLK_HZ/BAUD clocks. Bits are sampled in their middle, so the output strobe comes between 9.5 and 10 bit periods after the start edge. Two output strobes are never closer than 9 bit periods.
- R5: Data bits arrive least significant first. The first data bit lands in `rx_byte[0]` and the eighth in `rx_byte[7]`.
- R6: `rx_valid` is high for exactly one cycle per good frame. `rx_byte` changes only in a cycle where `rx_valid` is high.
- R7: A stop bit sampled low raises `rx_frame_err` for one cycle. There is no `rx_valid` for that frame, and `rx_byte` keeps its old value.
- R8: After the stop-bit sample the receiver is idle at once. A new start edge that comes 70% of the way into the stop bit is received.
- R9: Frames whose bit period differs from the nominal one by ±2.5% are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rx_byte | output | 8 | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| rx_frame_err | output | 1 | One-cycle strobe: stop bit was sampled low |

## Verification
The bench sends several byte values to tell bit order and bit position apart. These are alternating and single-bit patterns, all zeros and all ones. It times the output strobe against the start edge, which separates mid-bit sampling from sampling at the bit edge. Short low dips, a low stop bit followed by a line left low, stop bits cut to 70%, and bit periods 2.5% long or short each try one path: glitch rejection, framing error, edge-only start, early re-arming and drift margin. A reset in the middle of a frame checks that no partial byte or false start remains.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic line_o,
  output logic fall_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-1:0], raw_in};
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/rx_slot_ticker.sv
module rx_slot_ticker #(
  parameter int CLKS_PER_BIT = 217,
  parameter int SLOTS        = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick_o
);
  localparam int ACC_W = $clog2(CLKS_PER_BIT + SLOTS) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic             tick_q;

  // Adds SLOTS each clock and wraps at CLKS_PER_BIT: exactly SLOTS ticks per bit period
  assign acc_sum = acc_q + ACC_W'(SLOTS);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (acc_sum >= ACC_W'(CLKS_PER_BIT)) begin
      acc_q  <= acc_sum - ACC_W'(CLKS_PER_BIT);
      tick_q <= 1'b1;
    end else begin
      acc_q  <= acc_sum;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int SLOTS     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_i,
  input  logic                 fall_i,
  input  logic                 tick_i,
  output logic                 idle_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 valid_o,
  output logic                 ferr_o
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [SLOT_W-1:0] MID_SLOT  = SLOT_W'(SLOTS / 2 - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_BITS - 1);

  rx_state_t            state_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [BIT_W-1:0]     bit_q;
  logic [DATA_BITS-1:0] shift_q;
  logic [DATA_BITS-1:0] byte_q;
  logic                 valid_q;
  logic                 ferr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      slot_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          slot_q <= '0;
          bit_q  <= '0;
          if (fall_i) state_q <= RX_START;
        end
        RX_START: if (tick_i) begin
          if (slot_q == MID_SLOT) begin
            slot_q  <= '0;
            state_q <= line_i ? RX_IDLE : RX_DATA;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        RX_DATA: if (tick_i) begin
          if (slot_q == LAST_SLOT) begin
            slot_q  <= '0;
            shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
            if (bit_q == LAST_BIT) state_q <= RX_STOP;
            else                   bit_q   <= bit_q + 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        RX_STOP: if (tick_i) begin
          if (slot_q == LAST_SLOT) begin
            state_q <= RX_IDLE;
            if (line_i) begin
              byte_q  <= shift_q;
              valid_q <= 1'b1;
            end else begin
              ferr_q  <= 1'b1;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == RX_IDLE);
  assign byte_o  = byte_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
endmodule

// File: rtl/uart_rx_os16.sv
module uart_rx_os16 #(
  parameter int CLK_HZ      = 25_000_000,
  parameter int BAUD        = 115_200,
  parameter int DATA_BITS   = 8,
  parameter int SLOTS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_serial,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_frame_err
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;

  logic line_s;
  logic fall_s;
  logic tick_s;
  logic idle_s;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_in (rx_serial),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  rx_slot_ticker #(.CLKS_PER_BIT(CLKS_PER_BIT), .SLOTS(SLOTS)) u_ticker (
    .clk    (clk),
    .rst    (rst),
    .hold   (idle_s),
    .tick_o (tick_s)
  );

  rx_frame_fsm #(.DATA_BITS(DATA_BITS), .SLOTS(SLOTS)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .line_i  (line_s),
    .fall_i  (fall_s),
    .tick_i  (tick_s),
    .idle_o  (idle_s),
    .byte_o  (rx_byte),
    .valid_o (rx_valid),
    .ferr_o  (rx_frame_err)
  );
endmodule

// File: rtl/uart_rx_os16_checker.sv
module uart_rx_os16_checker #(
  parameter int CLK_HZ    = 25_000_000,
  parameter int BAUD      = 115_200,
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 rx_valid,
  input logic                 rx_frame_err
);
  localparam int CPB     = CLK_HZ / BAUD;
  localparam int MIN_GAP = 9 * CPB;
  localparam int GAP_W   = $clog2(MIN_GAP + 2) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic             out_s;

  assign out_s = rx_valid | rx_frame_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (out_s) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q < GAP_W'(MIN_GAP + 1)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R6
  AST_BYTE_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst) !$stable(rx_byte) |-> rx_valid); // R6
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) rx_frame_err |-> !rx_valid); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst) rx_frame_err |=> !rx_frame_err); // R7
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_s); // R1
  AST_FRAME_SPACING: assert property (@(posedge clk) disable iff (rst) (out_s && seen_q) |-> (gap_q >= GAP_W'(MIN_GAP - 1))); // R4
endmodule

bind uart_rx_os16 uart_rx_os16_checker #(
  .CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_BITS(DATA_BITS)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .rx_byte      (rx_byte),
  .rx_valid     (rx_valid),
  .rx_frame_err (rx_frame_err)
);

// File: tb/test_uart_rx_os16.sv
module test_uart_rx_os16;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int BAUD       = 100_000;
  localparam int CPB        = CLK_HZ / BAUD; // 40 clocks per bit

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_serial = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       rx_frame_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int n_valid = 0;
  int n_err = 0;
  int last_valid_cyc = 0;
  logic [7:0] last_byte = 8'h00;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_rx_os16 #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_uart_rx_os16 (
    .clk(clk), .rst(rst), .rx_serial(rx_serial),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      n_valid++;
      last_byte = rx_byte;
      last_valid_cyc = cyc;
    end
    if (!rst && rx_frame_err) n_err++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    @(negedge clk);
    rx_serial = 1'b1;
    repeat (n * CPB) @(negedge clk);
  endtask

  // one frame: start, 8 data LSB first, stop level held stop_len clocks, then line set to after_lvl
  task automatic send_frame(input logic [7:0] b, input logic stop_lvl, input int cpb,
                            input int stop_len, input logic after_lvl);
    @(negedge clk);
    rx_serial = 1'b0;
    repeat (cpb) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_serial = b[i];
      repeat (cpb) @(negedge clk);
    end
    rx_serial = stop_lvl;
    repeat (stop_len) @(negedge clk);
    rx_serial = after_lvl;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rx_serial = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    check(rx_valid == 0 && rx_frame_err == 0, "R1", "strobes in reset", rx_valid + rx_frame_err, 0);
    check(rx_byte == 0, "R1", "byte in reset", rx_byte, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rx_valid == 0 && rx_frame_err == 0, "R1", "strobes after reset", rx_valid + rx_frame_err, 0);
    idle_bits(12);
    check(n_valid == 0 && n_err == 0, "R1", "no false start after reset", n_valid + n_err, 0);
  endtask

  task automatic t_bytes();
    logic [7:0] pats [6] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h01, 8'h80};
    for (int k = 0; k < 6; k++) begin
      int nv = n_valid;
      send_frame(pats[k], 1'b1, CPB, CPB, 1'b1);
      idle_bits(1);
      check(n_valid == nv + 1, "R6", "one valid per frame", n_valid - nv, 1);
      check(last_byte == pats[k], "R5", "byte value", last_byte, pats[k]);
    end
    idle_bits(5);
    check(rx_byte == 8'h80, "R6", "byte held after valid", rx_byte, 8'h80);
  endtask

  task automatic t_timing();
    int t0;
    int dt;
    @(negedge clk);
    t0 = cyc;
    send_frame(8'h3C, 1'b1, CPB, CPB, 1'b1);
    dt = last_valid_cyc - t0;
    check(dt >= (19 * CPB) / 2 - 2 && dt <= 10 * CPB, "R4", "valid delay from start edge", dt, (19 * CPB) / 2);
    check(last_byte == 8'h3C, "R4", "byte with timing", last_byte, 8'h3C);
    idle_bits(1);
  endtask

  task automatic t_glitch();
    int nv = n_valid;
    int ne = n_err;
    @(negedge clk);
    rx_serial = 1'b0;
    repeat (5) @(negedge clk);
    rx_serial = 1'b1;
    idle_bits(12);
    check(n_valid == nv && n_err == ne, "R3", "short dip gives no output", (n_valid - nv) + (n_err - ne), 0);
    @(negedge clk);
    rx_serial = 1'b0;
    repeat (CPB / 2 - 8) @(negedge clk);
    rx_serial = 1'b1;
    idle_bits(12);
    check(n_valid == nv && n_err == ne, "R3", "longer dip gives no output", (n_valid - nv) + (n_err - ne), 0);
    send_frame(8'hC5, 1'b1, CPB, CPB, 1'b1);
    idle_bits(1);
    check(n_valid == nv + 1 && last_byte == 8'hC5, "R3", "frame after glitch", last_byte, 8'hC5);
  endtask

  task automatic t_frame_err();
    int nv = n_valid;
    int ne = n_err;
    send_frame(8'h5A, 1'b0, CPB, CPB, 1'b0);
    check(n_err == ne + 1, "R7", "framing error strobe", n_err - ne, 1);
    check(n_valid == nv, "R7", "no valid on bad stop", n_valid - nv, 0);
    check(rx_byte == 8'hC5, "R7", "byte kept on bad stop", rx_byte, 8'hC5);
    repeat (15 * CPB) @(negedge clk);
    check(n_valid == nv && n_err == ne + 1, "R2", "held-low line gives no output", (n_valid - nv) + (n_err - ne), 1);
    idle_bits(2);
  endtask

  task automatic t_back_to_back();
    int nv = n_valid;
    send_frame(8'h96, 1'b1, CPB, (CPB * 7) / 10, 1'b1);
    check(n_valid == nv + 1 && last_byte == 8'h96, "R8", "first short-stop frame", last_byte, 8'h96);
    send_frame(8'h69, 1'b1, CPB, (CPB * 7) / 10, 1'b1);
    check(n_valid == nv + 2 && last_byte == 8'h69, "R8", "second short-stop frame", last_byte, 8'h69);
    send_frame(8'hE1, 1'b1, CPB, CPB, 1'b1);
    check(n_valid == nv + 3 && last_byte == 8'hE1, "R8", "third frame after short stop", last_byte, 8'hE1);
    idle_bits(1);
  endtask

  task automatic t_drift();
    int nv = n_valid;
    send_frame(8'hB2, 1'b1, CPB + 1, CPB + 1, 1'b1);
    idle_bits(1);
    check(n_valid == nv + 1 && last_byte == 8'hB2, "R9", "slow sender +2.5%", last_byte, 8'hB2);
    send_frame(8'h4D, 1'b1, CPB - 1, CPB - 1, 1'b1);
    idle_bits(1);
    check(n_valid == nv + 2 && last_byte == 8'h4D, "R9", "fast sender -2.5%", last_byte, 8'h4D);
  endtask

  task automatic t_reset_midframe();
    int nv;
    int ne;
    @(negedge clk);
    rx_serial = 1'b0;
    repeat (3 * CPB) @(negedge clk);
    do_reset();
    check(rx_byte == 0, "R1", "byte cleared by reset", rx_byte, 0);
    nv = n_valid;
    ne = n_err;
    idle_bits(12);
    check(n_valid == nv && n_err == ne, "R1", "no output after mid-frame reset", (n_valid - nv) + (n_err - ne), 0);
    send_frame(8'h7E, 1'b1, CPB, CPB, 1'b1);
    idle_bits(1);
    check(n_valid == nv + 1 && last_byte == 8'h7E, "R1", "frame after mid-frame reset", last_byte, 8'h7E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_bytes();
    t_timing();
    t_glitch();
    t_frame_err();
    t_back_to_back();
    t_drift();
    t_reset_midframe();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule